// File: doc/BRIEF.md
# SPI Register Target with 10-bit Addressing

This block is an SPI target that opens a 10-bit register space to an external host. The host lowers the select line and sends two header bytes. The first header byte holds the upper part of the register address. The second holds the two lowest address bits and a direction flag. Any number of data bytes then follows, and the register address advances by one after every byte. Input bits are taken on rising SCLK edges and output bits change on falling SCLK edges, most significant bit first. The clock therefore idles low.

The serial pins are sampled by the system clock through synchronizers and are never used as clocks. SCLK must run at no more than a quarter of the system clock. The block reaches the registers through a simple strobe port, made of an address, a one-cycle write strobe with data and a one-cycle read strobe. Read data must be valid on `reg_rdata_i` in the same cycle as the read strobe. The data output has a separate enable. The pad drives the line only when that enable is high; otherwise the line is high-impedance.

Top module: `spi_reg_target`

## Requirements
- R1: After reset, `miso_oe_o`, `reg_wr_o` and `reg_rd_o` are all low.
- R2: Header byte one supplies address bits 9:2. In header byte two, bits 7:6 supply address bits 1:0 and bit 5 selects the direction, where 1 means write and 0 means read. Bits 4:0 of byte two have no effect on the address or on the data moved.
- R3: During a write, each complete 8-bit data byte is sampled MSB first on rising SCLK edges. It produces exactly one `reg_wr_o` pulse, with that byte on `reg_wdata_o` and the current address on `reg_addr_o`.
- R4: Successive data bytes in one transaction use consecutive addresses.
- R5: A data byte that is not complete when the select line rises produces no write.
- R6: During a read, the register at the header address is fetched with a `reg_rd_o` pulse once the header completes. Its bits appear on `miso_o` MSB first, each one changed on a falling SCLK edge. The next address is fetched after each byte's eighth rising edge.
- R7: `miso_oe_o` stays low while the select line is high, during both header bytes and for the whole of a write transaction. It goes high from the first falling edge after a read header.
- R8: Raising the select line at any point returns the interface to the start of a header.
- R9: The address wraps from 1023 to 0 during auto-increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host, idle low |
| ss_n_i | input | 1 | Target select, active low |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| miso_oe_o | output | 1 | Drive enable for the data-out pad (low = high-impedance) |
| reg_addr_o | output | ADDR_W | Register address |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | DATA_W | Write data |
| reg_rd_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | DATA_W | Read data, valid in the strobe cycle |

## Verification
The bench targets the places where the address is assembled and advanced:
- A design that took the direction flag with the opposite sense would turn writes into reads.
- One that decoded the don't-care bits of byte two would scatter writes to the wrong addresses.
- One that did not wrap the address at 1023 would write outside the register space.

It also stops transactions part-way:
- Halfway through a data byte. A design that commits partial bytes would emit a stray write.
- Halfway through a header. A design that kept its bit count across the select rise would misread the next address.

For reads, it compares every shifted-out bit against a computed register pattern, including the first bit. A wrong output-enable point or a missing first fetch would corrupt that bit.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

   typedef enum logic [1:0] {
      PH_HDR_HI = 2'd0,
      PH_HDR_LO = 2'd1,
      PH_WRITE  = 2'd2,
      PH_READ   = 2'd3
   } spi_phase_e;

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("spi_tgt_sync: WIDTH must be at least 1");
   end
   if (STAGES < 1) begin : g_bad_stages
      $error("spi_tgt_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic [WIDTH-1:0] r_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r_q <= RST_VAL;
         else        r_q <= d_i;
      end
      assign q_o = r_q;
   end else begin : g_chain
      logic [WIDTH-1:0] chain_q [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
         end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
         end
      end
      assign q_o = chain_q[STAGES-1];
   end

endmodule

// File: rtl/spi_tgt_edge.sv
module spi_tgt_edge #(
   parameter logic IDLE_LVL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic rise_o,
   output logic fall_o
);

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE_LVL;
      else        prev_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~prev_q;
   assign fall_o = ~lvl_i & prev_q;

endmodule

// File: rtl/spi_reg_target.sv
module spi_reg_target
   import spi_tgt_pkg::*;
#(
   parameter int ADDR_W      = 10,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              ss_n_i,
   input  logic              mosi_i,
   output logic              miso_o,
   output logic              miso_oe_o,
   output logic [ADDR_W-1:0] reg_addr_o,
   output logic              reg_wr_o,
   output logic [DATA_W-1:0] reg_wdata_o,
   output logic              reg_rd_o,
   input  logic [DATA_W-1:0] reg_rdata_i
);

   localparam int                CNT_W    = $clog2(DATA_W);
   localparam int                RW_BIT   = DATA_W - 3;
   localparam logic [CNT_W-1:0]  LAST_CNT = CNT_W'(DATA_W - 1);

   if (DATA_W < 4) begin : g_bad_data
      $error("spi_reg_target: DATA_W too small for the second header byte");
   end
   if (ADDR_W != DATA_W + 2) begin : g_bad_addr
      $error("spi_reg_target: ADDR_W must equal DATA_W + 2");
   end

   // ---------------- input synchronization ----------------
   logic [2:0] pins_s;
   logic       ss_s, sclk_s, mosi_s, ss_act;
   logic       sclk_rise, sclk_fall;

   spi_tgt_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({ss_n_i, sclk_i, mosi_i}),
      .q_o   (pins_s)
   );

   assign ss_s   = pins_s[2];
   assign sclk_s = pins_s[1];
   assign mosi_s = pins_s[0];
   assign ss_act = ~ss_s;

   spi_tgt_edge #(
      .IDLE_LVL (1'b0)
   ) i_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (sclk_s),
      .rise_o (sclk_rise),
      .fall_o (sclk_fall)
   );

   // ---------------- framing state ----------------
   spi_phase_e        phase_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] rx_q, tx_q, wdata_q;
   logic [ADDR_W-1:0] addr_q;
   logic              wr_q, rd_q, miso_q, oe_q;
   logic [DATA_W-1:0] rx_byte;
   logic              byte_done;

   assign rx_byte   = {rx_q[DATA_W-2:0], mosi_s};
   assign byte_done = ss_act & sclk_rise & (cnt_q == LAST_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_HDR_HI;
         cnt_q   <= '0;
         rx_q    <= '0;
         tx_q    <= '0;
         wdata_q <= '0;
         addr_q  <= '0;
         wr_q    <= 1'b0;
         rd_q    <= 1'b0;
         miso_q  <= 1'b0;
         oe_q    <= 1'b0;
      end else begin
         wr_q <= 1'b0;
         rd_q <= 1'b0;
         if (wr_q) addr_q <= addr_q + ADDR_W'(1);
         if (rd_q) tx_q   <= reg_rdata_i;
         if (!ss_act) begin
            phase_q <= PH_HDR_HI;
            cnt_q   <= '0;
            oe_q    <= 1'b0;
            miso_q  <= 1'b0;
         end else begin
            if (sclk_rise) begin
               rx_q  <= rx_byte;
               cnt_q <= byte_done ? '0 : cnt_q + CNT_W'(1);
               if (byte_done) begin
                  unique case (phase_q)
                     PH_HDR_HI: begin
                        addr_q[ADDR_W-1:2] <= rx_byte;
                        phase_q            <= PH_HDR_LO;
                     end
                     PH_HDR_LO: begin
                        addr_q[1:0] <= rx_byte[DATA_W-1 -: 2];
                        if (rx_byte[RW_BIT]) begin
                           phase_q <= PH_WRITE;
                        end else begin
                           phase_q <= PH_READ;
                           rd_q    <= 1'b1;
                        end
                     end
                     PH_WRITE: begin
                        wr_q    <= 1'b1;
                        wdata_q <= rx_byte;
                     end
                     PH_READ: begin
                        addr_q <= addr_q + ADDR_W'(1);
                        rd_q   <= 1'b1;
                     end
                     default: phase_q <= PH_HDR_HI;
                  endcase
               end
            end
            if (sclk_fall && phase_q == PH_READ) begin
               oe_q   <= 1'b1;
               miso_q <= tx_q[DATA_W-1];
               tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
            end
         end
      end
   end

   assign miso_o      = miso_q;
   assign miso_oe_o   = oe_q;
   assign reg_addr_o  = addr_q;
   assign reg_wr_o    = wr_q;
   assign reg_wdata_o = wdata_q;
   assign reg_rd_o    = rd_q;

   // ---------------- assertions ----------------
   // R7
   write_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_q |-> !oe_q);

   // R7
   idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ss_s |=> !oe_q);

   // R7
   header_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_HDR_HI || phase_q == PH_HDR_LO) |-> !oe_q);

   // R4
   wr_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_q |=> (addr_q == $past(addr_q) + ADDR_W'(1)));

   // R8
   ss_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ss_s |=> (cnt_q == '0 && phase_q == PH_HDR_HI));

   // R6
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_q && rd_q));

endmodule

// File: tb/test_spi_reg_target.sv
module test_spi_reg_target;

   localparam int AW = 10;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sclk = 1'b0;
   logic          ss_n = 1'b1;
   logic          mosi = 1'b0;
   logic          miso, miso_oe, reg_wr, reg_rd;
   logic [AW-1:0] reg_addr;
   logic [DW-1:0] reg_wdata, reg_rdata;

   int n_chk = 0;
   int n_fail = 0;
   int wr_seen = 0;
   bit finished = 1'b0;

   typedef struct packed {
      logic [AW-1:0] a;
      logic [DW-1:0] d;
   } wr_item_t;

   wr_item_t      exp_wr[$];
   logic [AW-1:0] exp_rd[$];

   always #10 clk = ~clk;

   function automatic logic [DW-1:0] model_rd(logic [AW-1:0] a);
      return a[7:0] ^ {a[9:8], 6'h2D};
   endfunction

   assign reg_rdata = model_rd(reg_addr);

   spi_reg_target i_spi_reg_target (
      .clk         (clk),
      .rst_n       (rst_n),
      .sclk_i      (sclk),
      .ss_n_i      (ss_n),
      .mosi_i      (mosi),
      .miso_o      (miso),
      .miso_oe_o   (miso_oe),
      .reg_addr_o  (reg_addr),
      .reg_wr_o    (reg_wr),
      .reg_wdata_o (reg_wdata),
      .reg_rd_o    (reg_rd),
      .reg_rdata_i (reg_rdata)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: pops expected strobes and compares
   always @(negedge clk) begin : monitor
      wr_item_t it;
      if (rst_n && !finished) begin
         if (reg_wr) begin
            wr_seen++;
            if (exp_wr.size() == 0) begin
               check(1'b0, "R5 unexpected write", int'(reg_addr), 0);
            end else begin
               it = exp_wr.pop_front();
               check(reg_addr == it.a, "R4 write address", int'(reg_addr), int'(it.a));
               check(reg_wdata == it.d, "R3 write data", int'(reg_wdata), int'(it.d));
            end
         end
         if (reg_rd) begin
            if (exp_rd.size() == 0) begin
               check(1'b0, "R6 unexpected read", int'(reg_addr), 0);
            end else begin
               check(reg_addr == exp_rd[0], "R6 read address", int'(reg_addr), int'(exp_rd[0]));
               void'(exp_rd.pop_front());
            end
         end
      end
   end

   task automatic spi_byte(input logic [7:0] tx, input int nbits, input bit exp_oe,
                           input string tag, output logic [7:0] rx);
      rx = '0;
      for (int i = 7; i >= 8 - nbits; i--) begin
         mosi = tx[i];
         repeat (8) @(negedge clk);
         rx[i] = miso;
         check(miso_oe == exp_oe, tag, int'(miso_oe), int'(exp_oe));
         sclk = 1'b1;
         repeat (8) @(negedge clk);
         sclk = 1'b0;
      end
   endtask

   task automatic sel_start();
      ss_n = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic sel_stop();
      repeat (8) @(negedge clk);
      ss_n = 1'b1;
      repeat (10) @(negedge clk);
      check(miso_oe == 1'b0, "R7 idle hiz", int'(miso_oe), 0);
   endtask

   task automatic header(input logic [AW-1:0] a, input bit wr, input logic [4:0] dc);
      logic [7:0] rx;
      spi_byte(a[9:2], 8, 1'b0, "R7 header hiz", rx);
      spi_byte({a[1:0], wr, dc}, 8, 1'b0, "R7 header hiz", rx);
   endtask

   task automatic spi_write(input logic [AW-1:0] a, input logic [4:0] dc,
                            input int n, input logic [7:0] seed);
      logic [7:0] rx, d;
      sel_start();
      header(a, 1'b1, dc);
      for (int k = 0; k < n; k++) begin
         d = seed + 8'(k * 8'h3B);
         exp_wr.push_back({a + AW'(k), d});
         spi_byte(d, 8, 1'b0, "R7 write hiz", rx);
      end
      sel_stop();
   endtask

   task automatic spi_read(input logic [AW-1:0] a, input logic [4:0] dc, input int n);
      logic [7:0] rx;
      logic [AW-1:0] ak;
      for (int k = 0; k <= n; k++) exp_rd.push_back(a + AW'(k));
      sel_start();
      header(a, 1'b0, dc);
      for (int k = 0; k < n; k++) begin
         ak = a + AW'(k);
         spi_byte(8'h00, 8, 1'b1, "R7 read drive", rx);
         check(rx == model_rd(ak), "R6 read data", int'(rx), int'(model_rd(ak)));
      end
      sel_stop();
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin : driver
      logic [7:0] rx;
      int base;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      // R1 reset state
      check(miso_oe == 1'b0, "R1 oe after reset", int'(miso_oe), 0);
      check(reg_wr == 1'b0, "R1 wr after reset", int'(reg_wr), 0);
      check(reg_rd == 1'b0, "R1 rd after reset", int'(reg_rd), 0);

      // R2 R3 R4: three-byte write, don't-care bits set
      spi_write(10'h2A5, 5'b10110, 3, 8'hC4);
      // R2: same address field with different don't-care bits
      spi_write(10'h2A5, 5'b00000, 1, 8'h5A);
      spi_write(10'h0C3, 5'b11111, 2, 8'h81);
      // R9: wrap at top of space
      spi_write(10'h3FF, 5'b01001, 2, 8'h17);

      // R5: partial data byte discarded
      base = wr_seen;
      exp_wr.push_back({10'h010, 8'h96});
      sel_start();
      header(10'h010, 1'b1, 5'b00011);
      spi_byte(8'h96, 8, 1'b0, "R7 write hiz", rx);
      spi_byte(8'hC3, 3, 1'b0, "R7 write hiz", rx);
      sel_stop();
      check(wr_seen - base == 1, "R5 partial byte writes", wr_seen - base, 1);

      // R8: abort mid-header, then a clean write
      base = wr_seen;
      sel_start();
      spi_byte(8'hFF, 8, 1'b0, "R7 header hiz", rx);
      spi_byte(8'hE0, 4, 1'b0, "R7 header hiz", rx);
      sel_stop();
      check(wr_seen == base, "R8 aborted header writes", wr_seen - base, 0);
      spi_write(10'h155, 5'b00100, 1, 8'h3C);
      check(wr_seen - base == 1, "R8 write after abort", wr_seen - base, 1);

      // R6: reads with auto-increment, wrap across 1023
      spi_read(10'h1FE, 5'b10101, 3);
      spi_read(10'h3FE, 5'b00000, 3);

      repeat (20) @(negedge clk);
      check(exp_wr.size() == 0, "R3 pending writes", exp_wr.size(), 0);
      check(exp_rd.size() == 0, "R6 pending reads", exp_rd.size(), 0);
      finished = 1'b1;
      summary();
      $finish;
   end

endmodule